// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Break Detection

This block receives asynchronous serial frames of eight or nine data bits, least significant bit first, using a one-cycle enable that occurs sixteen times per bit period. After a falling edge on the idle-high line, it confirms the start bit at mid-bit. It decides each data bit and the stop bit by a two-of-three vote over three samples around the bit centre. A good frame latches the byte and, in nine-bit mode, the extra bit, and raises a receive interrupt that stays set until the host clears it. A stop bit read as low sets a sticky framing error instead.

A separate counter watches the line for a long low condition. When it sees eleven bit periods of continuous low samples, it sets a sticky break flag. If the break-reset enable is set, it also sends a one-cycle reset request to the rest of the chip. A remap select chooses what appears on one control-bit output: either the framing error or a stored mode bit supplied by the surrounding register logic.

Top module: `uart_break_rx`

## Requirements
- R1: A high-to-low transition of the line seen on a tick begins a frame only if the line is still low on the eighth tick after it. Otherwise the receiver returns to idle and changes no output.
- R2: Each data bit and the stop bit take the majority value of samples on ticks 7, 8 and 9 of the bit period, counted from 0. A single deviant sample does not change the bit, and two deviant samples do.
- R3: On a frame whose stop bit votes high, `rxData` takes the eight data bits in order of arrival (first bit received in bit 0), and `rxIrq` becomes 1.
- R4: With `nineBitMode` = 1 at the start bit, the ninth received bit appears on `rxBit9`. With `nineBitMode` = 0, `rxBit9` is 0 after a good frame.
- R5: A stop bit that votes low sets `frameErr`, leaves `rxIrq` low and leaves `rxData` unchanged. `frameErr` remains set through later good frames.
- R6: `ctlBit7` equals `frameErr` when `errRemapSel` = 1, and equals `modeBitIn` when `errRemapSel` = 0.
- R7: Low samples on 176 consecutive ticks (11 bit periods) set the sticky `breakFlag`. A low stretch of 10 bit periods does not set it.
- R8: Break detection drives `breakRstReq` high for exactly one clock cycle when `brkRstEn` = 1, and does not drive it when `brkRstEn` = 0.
- R9: A high sample resets the break count. One unbroken low stretch produces at most one detection, however long it lasts.
- R10: A one-cycle `rxClear` clears `rxIrq`. A one-cycle `statClear` clears both `frameErr` and `breakFlag`.
- R11: After reset, `rxData`, `rxBit9`, `rxIrq`, `frameErr`, `breakFlag` and `breakRstReq` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| rxLine | input | 1 | Serial line, idle high |
| tick16 | input | 1 | One-cycle enable, 16 per bit period |
| nineBitMode | input | 1 | 1 selects nine data bits per frame |
| errRemapSel | input | 1 | 1 routes the framing error to ctlBit7 |
| modeBitIn | input | 1 | Stored mode bit shown on ctlBit7 when not remapped |
| brkRstEn | input | 1 | Allows a break to request a reset |
| rxClear | input | 1 | Clears the receive interrupt |
| statClear | input | 1 | Clears the framing error and break flags |
| rxData | output | 8 | Last good received byte |
| rxBit9 | output | 1 | Ninth bit of the last good frame |
| rxIrq | output | 1 | Receive interrupt flag |
| frameErr | output | 1 | Sticky framing error |
| breakFlag | output | 1 | Sticky break status |
| breakRstReq | output | 1 | One-cycle reset request on break |
| ctlBit7 | output | 1 | Framing error or mode bit, chosen by errRemapSel |

## Verification
Bit timing slipped by one tick would pull a bit's vote away from its centre. The first sign would be a two-tick mid-bit glitch that fails to flip the bit, or one that flips a bit it should not, seen on `rxData` at the end of that same frame. A break counter that fails to clear on a high sample, or that rearms without the line going high, shows on `breakFlag` within 10 low bit periods, or as a second `breakRstReq` cycle within one long low stretch. Wrong ownership of the flags, such as a clear that misses or a set on the wrong stop vote, appears on `rxIrq` or `frameErr` right after the stop bit's ninth tick.

// File: rtl/uart_break_rx_pkg.sv
package uart_break_rx_pkg;

  typedef enum logic [1:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_STOP
  } rxState_e;

  // Strobes from the bit-timing control to the datapath, valid for one cycle
  typedef struct packed {
    logic capA;    // take first vote sample
    logic capB;    // take second vote sample
    logic decide;  // third sample present: vote now
    logic isStop;  // the vote belongs to the stop bit
    logic nine;    // frame carries nine data bits
  } rxStrobe_t;

endpackage

// File: rtl/uart_break_rx_ctl.sv
module uart_break_rx_ctl
  import uart_break_rx_pkg::*;
#(
  parameter int OVERSAMPLE = 16
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      tick16,
  input  logic      rxS,
  input  logic      nineBitMode,
  output rxStrobe_t strb
);

  localparam int CW  = $clog2(OVERSAMPLE);
  localparam int MID = OVERSAMPLE / 2;
  localparam logic [CW-1:0] TICK_A   = CW'(MID - 1);
  localparam logic [CW-1:0] TICK_B   = CW'(MID);
  localparam logic [CW-1:0] TICK_C   = CW'(MID + 1);
  localparam logic [CW-1:0] TICK_TOP = CW'(OVERSAMPLE - 1);

  rxState_e      state;
  logic [CW-1:0] cnt;
  logic [CW-1:0] nxt;
  logic [3:0]    bitIdx;
  logic [3:0]    lastIdx;
  logic          lastS;
  logic          nineLat;
  logic          active;

  assign nxt     = (cnt == TICK_TOP) ? '0 : cnt + 1'b1;
  assign lastIdx = nineLat ? 4'd8 : 4'd7;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= RX_IDLE;
      cnt     <= '0;
      bitIdx  <= '0;
      lastS   <= 1'b1;
      nineLat <= 1'b0;
    end else if (tick16) begin
      lastS <= rxS;
      case (state)
        RX_IDLE: begin
          if (lastS && !rxS) begin
            state   <= RX_START;
            cnt     <= '0;
            nineLat <= nineBitMode;
          end
        end
        RX_START: begin
          cnt <= nxt;
          if (nxt == TICK_B && rxS) begin
            state <= RX_IDLE;
          end else if (nxt == '0) begin
            state  <= RX_DATA;
            bitIdx <= '0;
          end
        end
        RX_DATA: begin
          cnt <= nxt;
          if (nxt == '0) begin
            if (bitIdx == lastIdx) state <= RX_STOP;
            else bitIdx <= bitIdx + 4'd1;
          end
        end
        RX_STOP: begin
          cnt <= nxt;
          if (nxt == TICK_C) state <= RX_IDLE;
        end
        default: state <= RX_IDLE;
      endcase
    end
  end

  assign active = tick16 && (state == RX_DATA || state == RX_STOP);

  always_comb begin
    strb        = '0;
    strb.capA   = active && (nxt == TICK_A);
    strb.capB   = active && (nxt == TICK_B);
    strb.decide = active && (nxt == TICK_C);
    strb.isStop = (state == RX_STOP);
    strb.nine   = nineLat;
  end

  // R4: the data bit index never runs past the last bit of the frame size
  a_r4_bit_index_range: assert property (@(posedge clk) disable iff (!rstN)
    (state == RX_DATA) |-> (bitIdx <= lastIdx));

  // R2: the three vote strobes come on distinct cycles
  a_r2_strobes_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.capA, strb.capB, strb.decide}));

  // R1: leaving the start bit for data requires having passed mid-bit low
  a_r1_start_to_data: assert property (@(posedge clk) disable iff (!rstN)
    (state == RX_DATA && $past(state) == RX_START) |-> $past(cnt) == TICK_TOP);

endmodule

// File: rtl/uart_break_rx_dp.sv
module uart_break_rx_dp
  import uart_break_rx_pkg::*;
#(
  parameter int DATA_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 rxLine,
  input  rxStrobe_t            strb,
  input  logic                 rxClear,
  input  logic                 statClear,
  output logic                 rxS,
  output logic [DATA_BITS-1:0] rxData,
  output logic                 rxBit9,
  output logic                 rxIrq,
  output logic                 frameErr
);

  localparam int SW = DATA_BITS + 1;

  logic          syncA;
  logic          sA;
  logic          sB;
  logic          vote;
  logic [SW-1:0] shiftReg;
  logic          frameOk;
  logic          frameBad;

  // two-stage synchronizer, idle high
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA <= 1'b1;
      rxS   <= 1'b1;
    end else begin
      syncA <= rxLine;
      rxS   <= syncA;
    end
  end

  assign vote     = (sA & sB) | (sA & rxS) | (sB & rxS);
  assign frameOk  = strb.decide && strb.isStop && vote;
  assign frameBad = strb.decide && strb.isStop && !vote;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sA       <= 1'b1;
      sB       <= 1'b1;
      shiftReg <= '0;
    end else begin
      if (strb.capA) sA <= rxS;
      if (strb.capB) sB <= rxS;
      if (strb.decide && !strb.isStop) shiftReg <= {vote, shiftReg[SW-1:1]};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxData   <= '0;
      rxBit9   <= 1'b0;
      rxIrq    <= 1'b0;
      frameErr <= 1'b0;
    end else begin
      if (frameOk) begin
        if (strb.nine) begin
          rxData <= shiftReg[DATA_BITS-1:0];
          rxBit9 <= shiftReg[SW-1];
        end else begin
          rxData <= shiftReg[SW-1:1];
          rxBit9 <= 1'b0;
        end
      end
      if (frameOk) rxIrq <= 1'b1;
      else if (rxClear) rxIrq <= 1'b0;
      if (frameBad) frameErr <= 1'b1;
      else if (statClear) frameErr <= 1'b0;
    end
  end

  // R10: a clear with no frame completing leaves the interrupt low
  a_r10_irq_cleared: assert property (@(posedge clk) disable iff (!rstN)
    (rxClear && !frameOk) |=> !rxIrq);

  // R5: received data only moves when a frame ends
  a_r5_data_holds: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.decide && strb.isStop) |=> $stable(rxData));

  // R5: a rejected stop bit never raises the interrupt
  a_r5_bad_no_irq: assert property (@(posedge clk) disable iff (!rstN)
    (frameBad && !rxIrq) |=> !rxIrq);

endmodule

// File: rtl/uart_break_rx_brk.sv
module uart_break_rx_brk #(
  parameter int OVERSAMPLE = 16,
  parameter int BREAK_BITS = 11
) (
  input  logic clk,
  input  logic rstN,
  input  logic tick16,
  input  logic rxS,
  input  logic brkRstEn,
  input  logic statClear,
  output logic breakFlag,
  output logic breakRstReq
);

  localparam int LIMIT = OVERSAMPLE * BREAK_BITS;
  localparam int BW    = $clog2(LIMIT + 1);
  localparam logic [BW-1:0] LAST = BW'(LIMIT - 1);
  localparam logic [BW-1:0] SAT  = BW'(LIMIT);

  logic [BW-1:0] lowCnt;
  logic          armed;
  logic          hit;

  assign hit = tick16 && !rxS && armed && (lowCnt == LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lowCnt <= '0;
      armed  <= 1'b1;
    end else if (tick16) begin
      if (rxS) begin
        lowCnt <= '0;
        armed  <= 1'b1;
      end else begin
        if (lowCnt != SAT) lowCnt <= lowCnt + 1'b1;
        if (hit) armed <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      breakFlag   <= 1'b0;
      breakRstReq <= 1'b0;
    end else begin
      breakRstReq <= hit && brkRstEn;
      if (hit) breakFlag <= 1'b1;
      else if (statClear) breakFlag <= 1'b0;
    end
  end

  // R8: the reset request lasts a single cycle
  a_r8_req_single: assert property (@(posedge clk) disable iff (!rstN)
    breakRstReq |=> !breakRstReq);

  // R8: no reset request without the enable
  a_r8_req_enabled: assert property (@(posedge clk) disable iff (!rstN)
    breakRstReq |-> $past(brkRstEn));

  // R7: a reset request always comes with the status flag
  a_r7_req_with_flag: assert property (@(posedge clk) disable iff (!rstN)
    breakRstReq |-> breakFlag);

  // R9: the detector rearms only after a high sample
  a_r9_rearm_on_high: assert property (@(posedge clk) disable iff (!rstN)
    $rose(armed) |-> $past(rxS));

endmodule

// File: rtl/uart_break_rx.sv
module uart_break_rx
  import uart_break_rx_pkg::*;
#(
  parameter int OVERSAMPLE = 16,
  parameter int BREAK_BITS = 11,
  parameter int DATA_BITS  = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 rxLine,
  input  logic                 tick16,
  input  logic                 nineBitMode,
  input  logic                 errRemapSel,
  input  logic                 modeBitIn,
  input  logic                 brkRstEn,
  input  logic                 rxClear,
  input  logic                 statClear,
  output logic [DATA_BITS-1:0] rxData,
  output logic                 rxBit9,
  output logic                 rxIrq,
  output logic                 frameErr,
  output logic                 breakFlag,
  output logic                 breakRstReq,
  output logic                 ctlBit7
);

  rxStrobe_t strb;
  logic      rxS;

  uart_break_rx_ctl #(.OVERSAMPLE(OVERSAMPLE)) u_ctl (
    .clk(clk), .rstN(rstN), .tick16(tick16), .rxS(rxS),
    .nineBitMode(nineBitMode), .strb(strb)
  );

  uart_break_rx_dp #(.DATA_BITS(DATA_BITS)) u_dp (
    .clk(clk), .rstN(rstN), .rxLine(rxLine), .strb(strb),
    .rxClear(rxClear), .statClear(statClear), .rxS(rxS),
    .rxData(rxData), .rxBit9(rxBit9), .rxIrq(rxIrq), .frameErr(frameErr)
  );

  uart_break_rx_brk #(.OVERSAMPLE(OVERSAMPLE), .BREAK_BITS(BREAK_BITS)) u_brk (
    .clk(clk), .rstN(rstN), .tick16(tick16), .rxS(rxS),
    .brkRstEn(brkRstEn), .statClear(statClear),
    .breakFlag(breakFlag), .breakRstReq(breakRstReq)
  );

  assign ctlBit7 = errRemapSel ? frameErr : modeBitIn;

endmodule

// File: tb/uart_break_rx_tb.sv
`timescale 1ns/1ps
module uart_break_rx_tb;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       rxLine = 1'b1;
  logic       tick16;
  logic       nineBitMode = 1'b0;
  logic       errRemapSel = 1'b0;
  logic       modeBitIn = 1'b0;
  logic       brkRstEn = 1'b1;
  logic       rxClear = 1'b0;
  logic       statClear = 1'b0;
  logic [7:0] rxData;
  logic       rxBit9, rxIrq, frameErr, breakFlag, breakRstReq, ctlBit7;

  int total = 0;
  int fails = 0;
  int pulseCnt = 0;
  bit done = 0;
  logic [1:0] div = '0;

  always #5 clk = ~clk;

  always @(posedge clk) begin
    if (!rstN) div <= '0;
    else div <= div + 2'd1;
    if (breakRstReq) pulseCnt <= pulseCnt + 1;
  end
  assign tick16 = (div == 2'd3);

  uart_break_rx u_dut (
    .clk(clk), .rstN(rstN), .rxLine(rxLine), .tick16(tick16),
    .nineBitMode(nineBitMode), .errRemapSel(errRemapSel), .modeBitIn(modeBitIn),
    .brkRstEn(brkRstEn), .rxClear(rxClear), .statClear(statClear),
    .rxData(rxData), .rxBit9(rxBit9), .rxIrq(rxIrq), .frameErr(frameErr),
    .breakFlag(breakFlag), .breakRstReq(breakRstReq), .ctlBit7(ctlBit7)
  );

  // {nine, bits[8:0] first-received in bit 0, stop}
  localparam logic [10:0] VEC [8] = '{
    {1'b0, 9'h0A5, 1'b1},
    {1'b0, 9'h03C, 1'b1},
    {1'b1, 9'h1FF, 1'b1},
    {1'b1, 9'h100, 1'b1},
    {1'b0, 9'h0FF, 1'b0},
    {1'b1, 9'h055, 1'b1},
    {1'b1, 9'h0AA, 1'b0},
    {1'b0, 9'h000, 1'b1}
  };

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic waitTick();
    do @(negedge clk); while (!tick16);
    @(posedge clk);
    #1;
  endtask

  task automatic hold(logic v, int n);
    rxLine = v;
    for (int k = 0; k < n; k++) waitTick();
  endtask

  task automatic sendBit(logic v, int glitchN);
    if (glitchN == 0) hold(v, 16);
    else begin
      hold(v, 8);
      hold(!v, glitchN);
      hold(v, 16 - 8 - glitchN);
    end
  endtask

  task automatic sendFrame(logic nine, logic [8:0] bits, logic stop, int gBit, int gN);
    hold(1'b0, 16);
    for (int i = 0; i < (nine ? 9 : 8); i++) sendBit(bits[i], (i == gBit) ? gN : 0);
    sendBit(stop, 0);
    hold(1'b1, 4);
  endtask

  task automatic clearAll();
    @(negedge clk);
    rxClear = 1'b1;
    statClear = 1'b1;
    @(negedge clk);
    rxClear = 1'b0;
    statClear = 1'b0;
  endtask

  initial begin
    #1_500_000;
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    logic [7:0] lastData;
    lastData = 8'h00;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R11 reset state
    chk("R11 data", rxData, 0);
    chk("R11 bit9", rxBit9, 0);
    chk("R11 irq", rxIrq, 0);
    chk("R11 ferr", frameErr, 0);
    chk("R11 break", breakFlag, 0);
    chk("R11 rstreq", breakRstReq, 0);
    hold(1'b1, 4);

    // vector table: R3, R4, R5
    for (int i = 0; i < 8; i++) begin
      logic [10:0] v;
      v = VEC[i];
      clearAll();
      nineBitMode = v[10];
      sendFrame(v[10], v[9:1], v[0], -1, 0);
      @(negedge clk);
      if (v[0]) begin
        chk("R3 data", rxData, v[8:1]);
        chk("R3 irq", rxIrq, 1);
        chk("R4 bit9", rxBit9, v[10] ? v[9] : 1'b0);
        chk("R5 ferr clear on good", frameErr, 0);
        lastData = v[8:1];
      end else begin
        chk("R5 ferr set", frameErr, 1);
        chk("R5 no irq", rxIrq, 0);
        chk("R5 data kept", rxData, lastData);
      end
    end

    // R5 sticky through a good frame, R6 remap, R10 clears
    nineBitMode = 1'b0;
    clearAll();
    sendFrame(1'b0, 9'h011, 1'b0, -1, 0);
    sendFrame(1'b0, 9'h022, 1'b1, -1, 0);
    @(negedge clk);
    chk("R5 sticky", frameErr, 1);
    chk("R3 after error", rxData, 8'h22);
    errRemapSel = 1'b1; modeBitIn = 1'b0;
    @(negedge clk);
    chk("R6 remap shows ferr", ctlBit7, 1);
    errRemapSel = 1'b0; modeBitIn = 1'b1;
    @(negedge clk);
    chk("R6 mode bit one", ctlBit7, 1);
    modeBitIn = 1'b0;
    @(negedge clk);
    chk("R6 mode bit zero", ctlBit7, 0);
    @(negedge clk); rxClear = 1'b1; @(negedge clk); rxClear = 1'b0;
    chk("R10 irq cleared", rxIrq, 0);
    chk("R10 ferr kept by rxClear", frameErr, 1);
    @(negedge clk); statClear = 1'b1; @(negedge clk); statClear = 1'b0;
    chk("R10 ferr cleared", frameErr, 0);
    errRemapSel = 1'b1;
    @(negedge clk);
    chk("R6 remap shows cleared", ctlBit7, 0);
    errRemapSel = 1'b0;

    // R2 majority vote
    clearAll();
    sendFrame(1'b0, 9'h05A, 1'b1, 1, 1);
    @(negedge clk);
    chk("R2 single glitch ignored", rxData, 8'h5A);
    clearAll();
    sendFrame(1'b0, 9'h05A, 1'b1, 1, 2);
    @(negedge clk);
    chk("R2 double glitch flips", rxData, 8'h58);
    clearAll();
    sendFrame(1'b0, 9'h05A, 1'b1, 0, 2);
    @(negedge clk);
    chk("R2 double glitch on zero", rxData, 8'h5B);

    // R1 short start pulse is rejected
    clearAll();
    hold(1'b0, 4);
    hold(1'b1, 24);
    @(negedge clk);
    chk("R1 no irq", rxIrq, 0);
    chk("R1 no ferr", frameErr, 0);
    chk("R1 data kept", rxData, 8'h5B);

    // R7 ten low bits: no break
    clearAll();
    pulseCnt = 0;
    hold(1'b0, 160);
    hold(1'b1, 20);
    @(negedge clk);
    chk("R7 ten bits no break", breakFlag, 0);
    chk("R8 no pulse without break", pulseCnt, 0);

    // R7, R8, R9 long low stretch
    clearAll();
    pulseCnt = 0;
    brkRstEn = 1'b1;
    hold(1'b0, 384);
    @(negedge clk);
    chk("R7 break flagged", breakFlag, 1);
    chk("R9 one pulse in long low", pulseCnt, 1);
    hold(1'b1, 20);
    @(negedge clk);
    chk("R7 break sticky", breakFlag, 1);
    @(negedge clk); statClear = 1'b1; @(negedge clk); statClear = 1'b0;
    chk("R10 break cleared", breakFlag, 0);

    // R8 disabled request, R9 rearm after high
    pulseCnt = 0;
    brkRstEn = 1'b0;
    hold(1'b0, 192);
    hold(1'b1, 20);
    @(negedge clk);
    chk("R8 flag without enable", breakFlag, 1);
    chk("R8 no pulse when disabled", pulseCnt, 0);

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule